// File: doc/BRIEF.md
# Pipelined Texture Fraction Bit Evaluator

This block turns the result of a perspective-correct integer texture stepper into a full fixed-point texture coordinate. For each pixel it receives the integer coordinate `u`, the midpoint error term `E'` left over at integer resolution, and the per-pixel denominator `d`. From these it computes `FRAC_W` fraction bits, default 4, by a restoring digit recurrence. Each stage decides one bit with a single adder and hands its corrected error term to the next stage.

The stages form a cascade of registers, so a new pixel is accepted on every clock. The finished coordinate `{u, fraction}` leaves the block after a fixed latency. No state is carried from one pixel to the next, and every pixel's fraction depends only on its own inputs. The block sits after the integer stepper and feeds texture filtering, which uses the fraction bits as filter weights. Internally, `E'` and `d` are widened by `FRAC_W` guard bits so that the halving of `d` at each stage is exact.

Top module: `frac_evaluator`

## Requirements
- R1: For a valid input with `d > 0` and `-d < E' <= 0` (both two's complement, `ERR_W` bits), `coordOut` equals `{u, floor(2^FRAC_W * (-E') / d)}`. The integer part occupies the upper `INT_W` bits and the fraction the lower `FRAC_W` bits, with the most significant fraction bit first. For inputs built from plane values as `d = 2*den` and `E' = u*d - 2*num`, this is `floor(2^FRAC_W * num / den)`.
- R2: Stage k (k = 0 is the first stage) produces fraction bit `FRAC_W-1-k`. It forms `E' + d/2^(k+1)`. If that sum is at most 0, the bit is 1 and `E'` takes the sum; otherwise the bit is 0 and `E'` is unchanged. After stage k the residual therefore lies in `(-d/2^(k+1), 0]`.
- R3: `E' = 0` gives an all-zero fraction. `E' = -d/2` exactly gives fraction `1000` (binary). The most negative legal `E'` gives the largest fraction that the truncation rule allows.
- R4: The result for a pixel presented with `inValid` high at one rising edge appears with `outValid` high exactly `FRAC_W` rising edges later.
- R5: A new pixel may be presented on every clock. Results come out in order, one per clock, each unaffected by its neighbours.
- R6: While `outValid` is low, `coordOut` keeps its last value.
- R7: After reset, `outValid` is 0 and `coordOut` is 0.
- R8: The integer part `u` passes through unchanged and is aligned with its own fraction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input pixel present |
| inErr | input | ERR_W | Integer-level midpoint error E', signed, in (-d, 0] |
| inDen | input | ERR_W | Denominator d, signed, positive |
| inU | input | INT_W | Integer texture coordinate |
| outValid | output | 1 | Result present |
| coordOut | output | INT_W+FRAC_W | Fixed-point coordinate {integer, fraction} |

## Verification
On every cycle, the assertions check that the valid flag advances exactly one stage per clock and that each stage's residual stays inside the window its bit position allows. They also check that the output holds whenever no result is presented and that every accepted input meets the range contract. Only the bench scenarios can show that the numerical result equals the truncated quotient. Those scenarios cover the exact half-way boundary and the extreme error values. They also show that back-to-back and gapped streams keep order and that the latency is exactly four clocks.

// File: rtl/frac_eval_pkg.sv
package frac_eval_pkg;
  // Number of fraction bits; one pipeline stage per bit.
  parameter int FRAC_W = 4;

  // Strobes from control to datapath: per-stage register load enables.
  typedef struct packed {
    logic [FRAC_W-1:0] load;
  } strobe_t;
endpackage

// File: rtl/frac_bit_stage.sv
module frac_bit_stage #(
  parameter int SW    = 28,
  parameter int UW    = 12,
  parameter int FW    = 4,
  parameter int STAGE = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic signed [SW-1:0] errIn,
  input  logic signed [SW-1:0] denIn,
  input  logic        [UW-1:0] uIn,
  input  logic        [FW-1:0] bitsIn,
  output logic signed [SW-1:0] errOut,
  output logic signed [SW-1:0] denOut,
  output logic        [UW-1:0] uOut,
  output logic        [FW-1:0] bitsOut
);
  localparam int SHIFT = STAGE + 1;
  localparam int POS   = FW - 1 - STAGE;

  logic signed [SW-1:0] step;
  logic signed [SW-1:0] trial;
  logic                 take;
  logic signed [SW-1:0] errNext;
  logic        [FW-1:0] bitsNext;

  // Guard bits make this shift exact for every stage.
  assign step  = denIn >>> SHIFT;
  assign trial = errIn + step;
  assign take  = trial[SW-1] || (trial == '0);

  always_comb begin
    bitsNext      = bitsIn;
    bitsNext[POS] = take;
    errNext       = take ? trial : errIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errOut  <= '0;
      denOut  <= '0;
      uOut    <= '0;
      bitsOut <= '0;
    end else if (load) begin
      errOut  <= errNext;
      denOut  <= denIn;
      uOut    <= uIn;
      bitsOut <= bitsNext;
    end
  end
endmodule

// File: rtl/frac_ctrl.sv
module frac_ctrl
  import frac_eval_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output strobe_t           strobes,
  output logic [FRAC_W-1:0] stageValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= '0;
    end else begin
      stageValid[0] <= inValid;
      for (int s = 1; s < FRAC_W; s++) begin
        stageValid[s] <= stageValid[s-1];
      end
    end
  end

  always_comb begin
    strobes.load[0] = inValid;
    for (int s = 1; s < FRAC_W; s++) begin
      strobes.load[s] = stageValid[s-1];
    end
  end
endmodule

// File: rtl/frac_datapath.sv
module frac_datapath
  import frac_eval_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int INT_W = 12,
  localparam int SW   = ERR_W + FRAC_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobes,
  input  logic        [ERR_W-1:0]      inErr,
  input  logic        [ERR_W-1:0]      inDen,
  input  logic        [INT_W-1:0]      inU,
  output logic        [INT_W+FRAC_W-1:0] coordOut,
  output logic [FRAC_W-1:0][SW-1:0]    stageErr,
  output logic [FRAC_W-1:0][SW-1:0]    stageDen
);
  logic signed [SW-1:0]     errChain  [FRAC_W+1];
  logic signed [SW-1:0]     denChain  [FRAC_W+1];
  logic        [INT_W-1:0]  uChain    [FRAC_W+1];
  logic        [FRAC_W-1:0] bitsChain [FRAC_W+1];

  // Append guard bits: scaling by 2^FRAC_W keeps all shifts exact.
  assign errChain[0]  = {inErr, {FRAC_W{1'b0}}};
  assign denChain[0]  = {inDen, {FRAC_W{1'b0}}};
  assign uChain[0]    = inU;
  assign bitsChain[0] = '0;

  for (genvar s = 0; s < FRAC_W; s++) begin : g_stage
    frac_bit_stage #(
      .SW(SW), .UW(INT_W), .FW(FRAC_W), .STAGE(s)
    ) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobes.load[s]),
      .errIn  (errChain[s]),
      .denIn  (denChain[s]),
      .uIn    (uChain[s]),
      .bitsIn (bitsChain[s]),
      .errOut (errChain[s+1]),
      .denOut (denChain[s+1]),
      .uOut   (uChain[s+1]),
      .bitsOut(bitsChain[s+1])
    );
    assign stageErr[s] = errChain[s+1];
    assign stageDen[s] = denChain[s+1];
  end

  assign coordOut = {uChain[FRAC_W], bitsChain[FRAC_W]};
endmodule

// File: rtl/frac_evaluator.sv
module frac_evaluator
  import frac_eval_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int INT_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [ERR_W-1:0]          inErr,
  input  logic [ERR_W-1:0]          inDen,
  input  logic [INT_W-1:0]          inU,
  output logic                      outValid,
  output logic [INT_W+FRAC_W-1:0]   coordOut
);
  localparam int SW = ERR_W + FRAC_W;

  strobe_t                  strobes;
  logic [FRAC_W-1:0]        stageValid;
  logic [FRAC_W-1:0][SW-1:0] stageErr;
  logic [FRAC_W-1:0][SW-1:0] stageDen;

  frac_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strobes   (strobes),
    .stageValid(stageValid)
  );

  frac_datapath #(.ERR_W(ERR_W), .INT_W(INT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inErr   (inErr),
    .inDen   (inDen),
    .inU     (inU),
    .coordOut(coordOut),
    .stageErr(stageErr),
    .stageDen(stageDen)
  );

  assign outValid = stageValid[FRAC_W-1];
endmodule

// File: rtl/frac_evaluator_chk.sv
module frac_evaluator_chk
  import frac_eval_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int INT_W = 12,
  localparam int SW   = ERR_W + FRAC_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic [ERR_W-1:0]           inErr,
  input logic [ERR_W-1:0]           inDen,
  input logic                       outValid,
  input logic [INT_W+FRAC_W-1:0]    coordOut,
  input logic [FRAC_W-1:0]          stageValid,
  input logic [FRAC_W-1:0][SW-1:0]  stageErr,
  input logic [FRAC_W-1:0][SW-1:0]  stageDen
);
  // R1: accepted inputs meet the range contract.
  p_input_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ($signed(inDen) > 0 && $signed(inErr) <= 0 &&
                 $signed(inErr) > -$signed(inDen)));

  // R4: the valid flag enters the first stage one clock after input.
  p_valid_enter_r4: assert property (@(posedge clk) disable iff (!rstN)
    stageValid[0] == $past(inValid));

  for (genvar s = 0; s < FRAC_W; s++) begin : g_stage_chk
    // R2: residual after stage s lies in (-d/2^(s+1), 0].
    p_residual_window_r2: assert property (@(posedge clk) disable iff (!rstN)
      stageValid[s] |-> ($signed(stageErr[s]) <= 0 &&
        $signed(stageErr[s]) > -($signed(stageDen[s]) >>> (s + 1))));
    if (s > 0) begin : g_adv
      // R4: valid advances exactly one stage per clock.
      p_valid_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
        stageValid[s] == $past(stageValid[s-1]));
    end
  end

  // R6: no result presented means the output is held.
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(coordOut));
endmodule

bind frac_evaluator frac_evaluator_chk #(.ERR_W(ERR_W), .INT_W(INT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inErr     (inErr),
  .inDen     (inDen),
  .outValid  (outValid),
  .coordOut  (coordOut),
  .stageValid(stageValid),
  .stageErr  (stageErr),
  .stageDen  (stageDen)
);

// File: tb/frac_evaluator_bench.sv
module frac_evaluator_bench;
  localparam int ERR_W = 24;
  localparam int INT_W = 12;
  localparam int FW    = 4;
  localparam int CW    = INT_W + FW;
  localparam int NMAX  = 512;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [ERR_W-1:0] inErr = '0;
  logic [ERR_W-1:0] inDen = '0;
  logic [INT_W-1:0] inU = '0;
  logic          outValid;
  logic [CW-1:0] coordOut;

  int checks = 0;
  int errors = 0;
  longint lastCoord = 0;

  longint pNum [NMAX];
  longint pDen [NMAX];
  bit     pVal [NMAX];

  always #4 clk = ~clk;

  frac_evaluator #(.ERR_W(ERR_W), .INT_W(INT_W)) u_frac_evaluator (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inErr(inErr),
    .inDen(inDen), .inU(inU), .outValid(outValid), .coordOut(coordOut)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a pixel given plane values num/den: d = 2den, E' = u*d - 2num.
  task automatic drive(bit v, longint num, longint den);
    longint u, d, e;
    u = num / den;
    d = 2 * den;
    e = u * d - 2 * num;
    inValid = v;
    inU     = INT_W'(u);
    inDen   = ERR_W'(d);
    inErr   = ERR_W'(e);
  endtask

  function automatic longint expCoord(longint num, longint den);
    return (num * 16) / den;
  endfunction

  // One pixel, checking latency and value.
  task automatic single(string req, longint num, longint den);
    @(negedge clk);
    drive(1'b1, num, den);
    @(negedge clk);
    drive(1'b0, 0, 1);
    for (int k = 1; k < FW; k++) begin
      check({req, "/R4 early"}, outValid, 0);
      @(negedge clk);
    end
    check({req, "/R4 valid"}, outValid, 1);
    check(req, coordOut, expCoord(num, den));
    lastCoord = expCoord(num, den);
  endtask

  // Stream n pixels; mode 1 inserts bubbles.
  task automatic stream(string req, int n, int mode);
    int K, L, M, R, S, T, x, y;
    for (int i = 0; i < n; i++) begin
      K = $urandom_range(255); L = $urandom_range(255); M = $urandom_range(1000);
      R = $urandom_range(63);  S = $urandom_range(63);  T = $urandom_range(1000, 1);
      x = $urandom_range(1023); y = $urandom_range(1023);
      pNum[i] = longint'(K) * x + longint'(L) * y + M;
      pDen[i] = longint'(R) * x + longint'(S) * y + T;
      if (pNum[i] / pDen[i] > 4095) pNum[i] = pNum[i] % (4095 * pDen[i]);
      pVal[i] = (mode == 0) ? 1'b1 : bit'((i % 3) != 1);
    end
    for (int c = 0; c < n + FW; c++) begin
      @(negedge clk);
      if (c >= FW) begin
        if (pVal[c-FW]) begin
          check({req, " valid"}, outValid, 1);
          check(req, coordOut, expCoord(pNum[c-FW], pDen[c-FW]));
          lastCoord = expCoord(pNum[c-FW], pDen[c-FW]);
        end else begin
          check("R6 idle", outValid, 0);
          check("R6 hold", coordOut, lastCoord);
        end
      end
      if (c < n) drive(pVal[c], pNum[c], pDen[c]);
      else drive(1'b0, 0, 1);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R7 valid", outValid, 0);
    check("R7 coord", coordOut, 0);
  endtask

  task automatic test_edges();
    single("R3 zero error", 40, 8);          // E'=0 -> frac 0000
    single("R3 half", 1, 2);                 // E'=-d/2 -> frac 1000
    single("R3 max frac", 15, 16);           // frac 1111
    single("R3 just below", 1023, 1024);     // floor(16*1023/1024)=15
    single("R8 integer", 4095 * 7 + 6, 7);   // largest integer part
    single("R1 third", 1, 3);                // frac 0101
  endtask

  task automatic test_idle_hold();
    @(negedge clk);
    check("R6 idle", outValid, 0);
    check("R6 hold", coordOut, lastCoord);
    repeat (3) @(negedge clk);
    check("R6 hold later", coordOut, lastCoord);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    test_reset();
    test_edges();
    test_idle_hold();
    stream("R5 back-to-back R1", 200, 0);
    stream("R5 gapped R1", 120, 1);
    test_idle_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule